// File: doc/BRIEF.md
# Serial Programming Host Sequencer

This block is the host side of an in-system programming link. It drives a target device's reset line and a three-wire serial link (clock, data out, data in), puts the target into serial programming mode, and writes one or more pages of program memory. Page data comes word by word from a small local buffer through a request/ready handshake. The block reports a level `done` when every page has been committed, or a level `err` when the target never acknowledged the enable instruction.

A run starts with a single-cycle `start` pulse. The block raises target reset for a configurable width while the serial clock is held low. It then waits a configurable settle time and sends the four-byte enable instruction. The third byte returned by the target must echo 0x53. If it does not, the full frame is still finished, reset is pulsed again and the enable is retried, up to a configurable number of attempts. Once the target is in sync, each word is loaded as a low-byte load and then a high-byte load. Each page is committed with a page-write instruction. Completion is then detected either by repeated polling of the target's busy bit or by a fixed wait.

All serial traffic uses 32-bit frames sent most significant bit first. The serial clock is the system clock divided down, with each half period lasting `HALF_CLKS` system clocks.

Top module: `sprog_seq`

## Requirements
- R1: Under reset and while idle, `tgt_rst`, `tgt_sck`, `done`, `err` and `buf_req` are all low.
- R2: After `start`, `tgt_rst` is high for at least `RST_W` clocks while `tgt_sck` stays low. It then stays low for at least `WAIT_CLKS` clocks before the first rising `tgt_sck` of the enable frame.
- R3: Each `tgt_sck` level lasts at least `HALF_CLKS` clocks. `tgt_mosi` changes only while `tgt_sck` is low. Bits go out most significant first, and `tgt_miso` is sampled on the rising clock edge.
- R4: The enable frame is bytes 0xAC 0x53 0x00 0x00. The byte returned while the third byte is sent is compared with 0x53. All 32 bits are always sent, whatever the result.
- R5: A wrong echo causes a new reset pulse, a new settle wait and a new enable frame. After `MAX_TRIES` wrong echoes, `err` rises and stays high, with no further `tgt_sck` or `tgt_rst` activity.
- R6: `buf_req` stays high with `buf_addr` held until `buf_rdy`. `buf_data` is taken in the same cycle as `buf_rdy`.
- R7: Each word goes out as frame {0x40, addr[15:8], addr[7:0], data[7:0]} and then frame {0x48, addr[15:8], addr[7:0], data[15:8]}. Here addr = page*PAGE_WORDS + offset, and offsets go up from 0.
- R8: After the last word of a page, the frame {0x4C, base[15:8], base[7:0], 0x00} is sent, where base is the page's first word address.
- R9: With `poll_en` low, at least `T_WD` clocks pass between the last rising `tgt_sck` of a page-write frame and the first rising `tgt_sck` of the next frame.
- R10: With `poll_en` high, frame 0xF0 0x00 0x00 0x00 is repeated while bit 0 of the returned fourth byte is 1. The next page starts after the first poll that returns 0.
- R11: Pages `pg_first` to `pg_first+pg_count-1` are written in increasing order. Then `done` rises and stays high until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle pulse that begins a programming run |
| poll_en | input | 1 | 1: poll the busy bit after a page write; 0: wait a fixed time |
| pg_first | input | AW-log2(PAGE_WORDS) | Number of the first page to write |
| pg_count | input | AW-log2(PAGE_WORDS) | Number of pages to write (at least 1) |
| buf_req | output | 1 | Request for one data word from the local buffer |
| buf_addr | output | AW | Word address being requested |
| buf_rdy | input | 1 | Buffer has placed the word on buf_data |
| buf_data | input | 16 | Requested program word |
| tgt_rst | output | 1 | Target reset line, high during a reset pulse |
| tgt_sck | output | 1 | Serial clock to target |
| tgt_mosi | output | 1 | Serial data to target |
| tgt_miso | input | 1 | Serial data from target |
| done | output | 1 | All requested pages are committed |
| err | output | 1 | Enable handshake failed MAX_TRIES times |

## Verification
The hardest situations to reach from the ports are a target that answers the enable instruction wrongly and then correctly, and a target that reports busy across several polls. The bench contains a behavioural target that decodes each incoming frame bit by bit. It corrupts the echo byte for a programmable number of enable frames, and it returns a busy bit for a programmable number of polls after each page write. Runs with one bad echo, with a permanently bad echo, with several busy polls, and with the top page number then check the captured frame stream against sequences computed in the bench.

// File: rtl/sprog_pkg.sv
package sprog_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RPULSE,
        S_RWAIT,
        S_EN,
        S_REQ,
        S_LDLO,
        S_LDHI,
        S_WRPG,
        S_POLL,
        S_TWAIT,
        S_DONE,
        S_ERR
    } seq_state_e;

    typedef enum logic [2:0] {
        FK_EN,
        FK_LDLO,
        FK_LDHI,
        FK_WR,
        FK_POLL
    } frame_kind_e;

    localparam logic [7:0] OP_EN0   = 8'hAC;
    localparam logic [7:0] OP_EN1   = 8'h53;
    localparam logic [7:0] OP_LD_LO = 8'h40;
    localparam logic [7:0] OP_LD_HI = 8'h48;
    localparam logic [7:0] OP_WR_PG = 8'h4C;
    localparam logic [7:0] OP_POLL  = 8'hF0;

endpackage

// File: rtl/sprog_shift.sv
module sprog_shift #(
    parameter int HALF_CLKS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] frame_i,
    input  logic        miso,
    output logic        sck,
    output logic        mosi,
    output logic        busy,
    output logic        done,
    output logic [31:0] rx_o
);
    localparam int CW = $clog2(HALF_CLKS);
    localparam int RW = $clog2(HALF_CLKS + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF_CLKS - 1);

    typedef struct packed {
        logic          busy;
        logic          sck;
        logic [CW-1:0] cnt;
        logic [4:0]    bitn;
        logic [31:0]   tx;
        logic [31:0]   rx;
        logic          done;
    } shf_t;

    shf_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.tx   = frame_i;
                d.cnt  = '0;
                d.bitn = '0;
                d.sck  = 1'b0;
            end
        end else if (q.cnt == LAST) begin
            d.cnt = '0;
            if (!q.sck) begin
                d.sck = 1'b1;
                d.rx  = {q.rx[30:0], miso};
            end else begin
                d.sck  = 1'b0;
                d.tx   = {q.tx[30:0], 1'b0};
                d.bitn = q.bitn + 5'd1;
                if (q.bitn == 5'd31) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end
            end
        end else begin
            d.cnt = q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck  = q.sck;
    assign mosi = q.tx[31];
    assign busy = q.busy;
    assign done = q.done;
    assign rx_o = q.rx;

    // half-period watch: cycles the previous sck level lasted
    logic          sck_prev_q;
    logic [RW-1:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev_q <= 1'b0;
            run_q      <= RW'(HALF_CLKS);
        end else begin
            sck_prev_q <= sck;
            if (sck != sck_prev_q)             run_q <= RW'(1);
            else if (run_q != RW'(HALF_CLKS))  run_q <= run_q + RW'(1);
        end
    end

    // R3: data line only moves while the clock line is low
    p_mosi_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi) |-> !sck);

    // R3: every clock level lasts at least HALF_CLKS cycles
    p_half_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sck != sck_prev_q) |-> (run_q >= RW'(HALF_CLKS)));

    // R4: a new frame is never started on top of a running one
    p_start_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

endmodule

// File: rtl/sprog_framer.sv
module sprog_framer
    import sprog_pkg::*;
#(
    parameter int AW = 16
) (
    input  frame_kind_e       kind,
    input  logic [AW-1:0]     addr,
    input  logic [15:0]       word,
    output logic [31:0]       frame
);
    logic [15:0] a16;
    assign a16 = 16'(addr);

    always_comb begin
        unique case (kind)
            FK_EN:   frame = {OP_EN0, OP_EN1, 8'h00, 8'h00};
            FK_LDLO: frame = {OP_LD_LO, a16[15:8], a16[7:0], word[7:0]};
            FK_LDHI: frame = {OP_LD_HI, a16[15:8], a16[7:0], word[15:8]};
            FK_WR:   frame = {OP_WR_PG, a16[15:8], a16[7:0], 8'h00};
            default: frame = {OP_POLL, 24'h000000};
        endcase
    end
endmodule

// File: rtl/sprog_ctrl.sv
module sprog_ctrl
    import sprog_pkg::*;
#(
    parameter int AW         = 16,
    parameter int PAGE_WORDS = 32,
    parameter int RST_W      = 40,
    parameter int WAIT_CLKS  = 400000,
    parameter int T_WD       = 90000,
    parameter int MAX_TRIES  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 poll_en,
    input  logic [AW-$clog2(PAGE_WORDS)-1:0] pg_first,
    input  logic [AW-$clog2(PAGE_WORDS)-1:0] pg_count,
    output logic                 buf_req,
    output logic [AW-1:0]        buf_addr,
    input  logic                 buf_rdy,
    input  logic [15:0]          buf_data,
    output logic                 tgt_rst,
    output logic                 fr_start,
    output frame_kind_e          fr_kind,
    output logic [AW-1:0]        fr_addr,
    output logic [15:0]          fr_word,
    input  logic                 fr_done,
    input  logic [31:0]          fr_rx,
    output logic                 done,
    output logic                 err
);
    localparam int OFFW = $clog2(PAGE_WORDS);
    localparam int PGW  = AW - OFFW;
    localparam int TM1  = (WAIT_CLKS > RST_W) ? WAIT_CLKS : RST_W;
    localparam int TMAX = (TM1 > T_WD) ? TM1 : T_WD;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int TRW  = $clog2(MAX_TRIES + 1);
    localparam logic [OFFW-1:0] LASTW = OFFW'(PAGE_WORDS - 1);

    typedef struct packed {
        seq_state_e      st;
        logic            sent;
        logic [TW-1:0]   timer;
        logic [TRW-1:0]  tries;
        logic [PGW-1:0]  page;
        logic [PGW-1:0]  left;
        logic [OFFW-1:0] word;
        logic [15:0]     data;
    } ctl_t;

    ctl_t q, d;
    logic adv;
    logic unused_rx;
    assign unused_rx = ^{fr_rx[31:16], fr_rx[7:1]};

    always_comb begin
        d   = q;
        adv = 1'b0;
        unique case (q.st)
            S_IDLE, S_DONE, S_ERR: begin
                if (start) begin
                    d.st    = S_RPULSE;
                    d.page  = pg_first;
                    d.left  = pg_count;
                    d.tries = '0;
                    d.timer = '0;
                    d.sent  = 1'b0;
                end
            end
            S_RPULSE: begin
                if (q.timer == TW'(RST_W - 1)) begin
                    d.timer = '0;
                    d.st    = S_RWAIT;
                end else begin
                    d.timer = q.timer + TW'(1);
                end
            end
            S_RWAIT: begin
                if (q.timer == TW'(WAIT_CLKS - 1)) begin
                    d.timer = '0;
                    d.st    = S_EN;
                end else begin
                    d.timer = q.timer + TW'(1);
                end
            end
            S_EN: begin
                if (!q.sent) begin
                    d.sent = 1'b1;
                end else if (fr_done) begin
                    d.sent = 1'b0;
                    if (fr_rx[15:8] == OP_EN1) begin
                        d.word = '0;
                        d.st   = S_REQ;
                    end else if (q.tries == TRW'(MAX_TRIES - 1)) begin
                        d.st = S_ERR;
                    end else begin
                        d.tries = q.tries + TRW'(1);
                        d.timer = '0;
                        d.st    = S_RPULSE;
                    end
                end
            end
            S_REQ: begin
                if (buf_rdy) begin
                    d.data = buf_data;
                    d.st   = S_LDLO;
                end
            end
            S_LDLO: begin
                if (!q.sent) begin
                    d.sent = 1'b1;
                end else if (fr_done) begin
                    d.sent = 1'b0;
                    d.st   = S_LDHI;
                end
            end
            S_LDHI: begin
                if (!q.sent) begin
                    d.sent = 1'b1;
                end else if (fr_done) begin
                    d.sent = 1'b0;
                    if (q.word == LASTW) begin
                        d.st = S_WRPG;
                    end else begin
                        d.word = q.word + OFFW'(1);
                        d.st   = S_REQ;
                    end
                end
            end
            S_WRPG: begin
                if (!q.sent) begin
                    d.sent = 1'b1;
                end else if (fr_done) begin
                    d.sent  = 1'b0;
                    d.timer = '0;
                    d.st    = poll_en ? S_POLL : S_TWAIT;
                end
            end
            S_POLL: begin
                if (!q.sent) begin
                    d.sent = 1'b1;
                end else if (fr_done) begin
                    d.sent = 1'b0;
                    adv    = !fr_rx[0];
                end
            end
            S_TWAIT: begin
                if (q.timer == TW'(T_WD - 1)) begin
                    d.timer = '0;
                    adv     = 1'b1;
                end else begin
                    d.timer = q.timer + TW'(1);
                end
            end
            default: d.st = S_IDLE;
        endcase

        if (adv) begin
            if (q.left == PGW'(1)) begin
                d.st = S_DONE;
            end else begin
                d.page = q.page + PGW'(1);
                d.left = q.left - PGW'(1);
                d.word = '0;
                d.st   = S_REQ;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        unique case (q.st)
            S_LDLO:  fr_kind = FK_LDLO;
            S_LDHI:  fr_kind = FK_LDHI;
            S_WRPG:  fr_kind = FK_WR;
            S_POLL:  fr_kind = FK_POLL;
            default: fr_kind = FK_EN;
        endcase
    end

    assign fr_start = !q.sent && (q.st == S_EN || q.st == S_LDLO || q.st == S_LDHI ||
                                  q.st == S_WRPG || q.st == S_POLL);
    assign fr_addr  = (q.st == S_WRPG) ? {q.page, {OFFW{1'b0}}} : {q.page, q.word};
    assign fr_word  = q.data;
    assign buf_req  = (q.st == S_REQ);
    assign buf_addr = {q.page, q.word};
    assign tgt_rst  = (q.st == S_RPULSE);
    assign done     = (q.st == S_DONE);
    assign err      = (q.st == S_ERR);

    // R6: an open request keeps its address until the buffer answers
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_req && !buf_rdy) |=> (buf_req && $stable(buf_addr)));

    // R11: completion level persists until a new start
    p_done_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

endmodule

// File: rtl/sprog_seq.sv
module sprog_seq
    import sprog_pkg::*;
#(
    parameter int AW         = 16,
    parameter int PAGE_WORDS = 32,
    parameter int HALF_CLKS  = 4,
    parameter int RST_W      = 40,
    parameter int WAIT_CLKS  = 400000,
    parameter int T_WD       = 90000,
    parameter int MAX_TRIES  = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic                              poll_en,
    input  logic [AW-$clog2(PAGE_WORDS)-1:0]  pg_first,
    input  logic [AW-$clog2(PAGE_WORDS)-1:0]  pg_count,
    output logic                              buf_req,
    output logic [AW-1:0]                     buf_addr,
    input  logic                              buf_rdy,
    input  logic [15:0]                       buf_data,
    output logic                              tgt_rst,
    output logic                              tgt_sck,
    output logic                              tgt_mosi,
    input  logic                              tgt_miso,
    output logic                              done,
    output logic                              err
);
    logic          fr_start, fr_done, fr_busy;
    frame_kind_e   fr_kind;
    logic [AW-1:0] fr_addr;
    logic [15:0]   fr_word;
    logic [31:0]   fr_frame, fr_rx;

    sprog_ctrl #(
        .AW(AW), .PAGE_WORDS(PAGE_WORDS), .RST_W(RST_W),
        .WAIT_CLKS(WAIT_CLKS), .T_WD(T_WD), .MAX_TRIES(MAX_TRIES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .poll_en(poll_en),
        .pg_first(pg_first), .pg_count(pg_count),
        .buf_req(buf_req), .buf_addr(buf_addr), .buf_rdy(buf_rdy), .buf_data(buf_data),
        .tgt_rst(tgt_rst), .fr_start(fr_start), .fr_kind(fr_kind), .fr_addr(fr_addr),
        .fr_word(fr_word), .fr_done(fr_done), .fr_rx(fr_rx), .done(done), .err(err)
    );

    sprog_framer #(.AW(AW)) u_framer (
        .kind(fr_kind), .addr(fr_addr), .word(fr_word), .frame(fr_frame)
    );

    sprog_shift #(.HALF_CLKS(HALF_CLKS)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(fr_start), .frame_i(fr_frame),
        .miso(tgt_miso), .sck(tgt_sck), .mosi(tgt_mosi), .busy(fr_busy),
        .done(fr_done), .rx_o(fr_rx)
    );

    // R2: serial clock stays low and no frame runs during a reset pulse
    p_rst_sck_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_rst |-> (!tgt_sck && !fr_busy));

    // R5: after giving up, the link is quiet
    p_err_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!tgt_sck && !tgt_rst && !fr_busy));

endmodule

// File: tb/sprog_seq_tb.sv
module sprog_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 16;
    localparam int PW   = 4;
    localparam int HALF = 4;
    localparam int RSTW = 8;
    localparam int WAIT = 200;
    localparam int TWD  = 300;
    localparam int MAXT = 3;
    localparam int PGW  = AW - $clog2(PW);

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, poll_en = 1'b0;
    logic [PGW-1:0] pg_first = '0, pg_count = PGW'(1);
    logic buf_rdy = 1'b0;
    logic [15:0] buf_data = '0;
    logic tgt_miso = 1'b0;
    logic buf_req, tgt_rst, tgt_sck, tgt_mosi, done, err;
    logic [AW-1:0] buf_addr;

    sprog_seq #(.AW(AW), .PAGE_WORDS(PW), .HALF_CLKS(HALF), .RST_W(RSTW),
                .WAIT_CLKS(WAIT), .T_WD(TWD), .MAX_TRIES(MAXT)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .poll_en(poll_en),
        .pg_first(pg_first), .pg_count(pg_count), .buf_req(buf_req),
        .buf_addr(buf_addr), .buf_rdy(buf_rdy), .buf_data(buf_data),
        .tgt_rst(tgt_rst), .tgt_sck(tgt_sck), .tgt_mosi(tgt_mosi),
        .tgt_miso(tgt_miso), .done(done), .err(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;

    // target model and link monitor state
    int bcnt = 0, nfr = 0, cur_start = 0;
    logic [31:0] sr = '0;
    logic [31:0] flog [0:63];
    int fst [0:63];
    int fen [0:63];
    logic [7:0] echo_b = '0;
    int bad_left = 0, busy_left = 0, busy_init = 0;
    int pulses = 0, rise_c = 0, last_fall = 0, wmin = 1000000, gmin = 1000000;
    bit gap_pend = 0;
    int last_tog = -1, hmin = 1000000, mosi_bad = 0, reqs = 0;
    logic pm = 1'b0;

    function automatic logic [15:0] wdata(int a);
        return 16'(a * 313 + 23100);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_ge(string tag, int act, int lim);
        checks++;
        if (act < lim) begin
            errors++;
            $display("FAIL %s actual=%0d expected>=%0d", tag, act, lim);
        end
    endtask

    always @(posedge tgt_rst) if (rst_n) begin
        bcnt = 0;
        pulses++;
        rise_c = cyc;
    end

    always @(negedge tgt_rst) if (rst_n) begin
        if (cyc - rise_c < wmin) wmin = cyc - rise_c;
        last_fall = cyc;
        gap_pend  = 1;
    end

    always @(tgt_sck) if (rst_n) begin
        if (last_tog >= 0 && cyc - last_tog < hmin) hmin = cyc - last_tog;
        last_tog = cyc;
    end

    always @(posedge tgt_sck) if (rst_n) begin
        if (bcnt == 0) begin
            cur_start = cyc;
            if (gap_pend && cyc - last_fall < gmin) gmin = cyc - last_fall;
            gap_pend = 0;
        end
        sr = {sr[30:0], tgt_mosi};
        bcnt++;
        if (bcnt == 32) begin
            if (nfr < 64) begin
                flog[nfr] = sr;
                fst[nfr]  = cur_start;
                fen[nfr]  = cyc;
            end
            nfr++;
            bcnt = 0;
            if (sr[31:24] == 8'hAC && bad_left > 0) bad_left--;
            if (sr[31:24] == 8'h4C) busy_left = busy_init;
            else if (sr[31:24] == 8'hF0 && busy_left > 0) busy_left--;
        end
    end

    always @(negedge tgt_sck) if (rst_n) begin
        if (bcnt == 16) echo_b = (bad_left > 0) ? 8'h00 : sr[7:0];
        if (bcnt >= 16 && bcnt <= 23) tgt_miso = echo_b[23-bcnt];
        else if (bcnt == 31)          tgt_miso = (sr[30:23] == 8'hF0) && (busy_left > 0);
        else                          tgt_miso = 1'b0;
    end

    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n && tgt_mosi !== pm && tgt_sck === 1'b1) mosi_bad++;
            pm = tgt_mosi;
        end
    end

    // local page buffer: answers after an address-dependent delay
    initial begin
        int dly = 0;
        forever begin
            @(negedge clk);
            if (buf_req && !buf_rdy) begin
                if (dly >= int'(buf_addr) % 3) begin
                    buf_rdy  = 1'b1;
                    buf_data = wdata(int'(buf_addr));
                    dly = 0;
                    reqs++;
                end else begin
                    dly++;
                end
            end else if (buf_rdy) begin
                buf_rdy = 1'b0;
            end
        end
    end

    task automatic clear_log();
        nfr = 0; pulses = 0; wmin = 1000000; gmin = 1000000;
        hmin = 1000000; mosi_bad = 0; reqs = 0; last_tog = -1;
    endtask

    task automatic run_wait();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (done || err) break;
        end
    endtask

    task automatic chk_page(int idx0, int page, int polls);
        for (int w = 0; w < PW; w++) begin
            int a = page * PW + w;
            logic [15:0] dw = wdata(a);
            chk("R7 low-byte load", flog[idx0+2*w],   {8'h40, 8'(a >> 8), 8'(a), dw[7:0]});
            chk("R7 high-byte load", flog[idx0+2*w+1], {8'h48, 8'(a >> 8), 8'(a), dw[15:8]});
        end
        chk("R8 page write", flog[idx0+2*PW], {8'h4C, 8'((page*PW) >> 8), 8'(page*PW), 8'h00});
        for (int p = 0; p < polls; p++)
            chk("R10 poll frame", flog[idx0+2*PW+1+p], 32'hF0000000);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset tgt_rst", tgt_rst, 0);
        chk("R1 reset sck", tgt_sck, 0);
        chk("R1 reset done/err/req", {done, err, buf_req}, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk("R1 idle outputs", {tgt_rst, tgt_sck, done, err, buf_req}, 0);

        // Run A: one wrong echo, fixed wait, two pages from page 5
        clear_log();
        bad_left = 1; busy_init = 0; poll_en = 1'b0;
        pg_first = PGW'(5); pg_count = PGW'(2);
        run_wait();
        chk("R11 done after run A", {done, err}, 2'b10);
        chk("R5 reset pulses with one bad echo", pulses, 2);
        chk("R4 frame count run A", nfr, 2 + 2*(2*PW+1));
        chk("R4 enable frame first try", flog[0], 32'hAC530000);
        chk("R5 enable frame reissued", flog[1], 32'hAC530000);
        chk_ge("R2 reset pulse width", wmin, RSTW);
        chk_ge("R2 settle before enable", gmin, WAIT);
        chk_page(2, 5, 0);
        chk_page(2 + 2*PW + 1, 6, 0);
        chk_ge("R9 fixed wait after write", fst[2*PW+3] - fen[2*PW+2], TWD);
        chk_ge("R3 half period", hmin, HALF);
        chk("R3 mosi stable while sck high", mosi_bad, 0);
        chk("R6 buffer words taken", reqs, 2*PW);
        repeat (50) @(negedge clk);
        chk("R11 done held", {done, tgt_sck, tgt_rst}, 3'b100);

        // Run B: polling with three busy answers per page, pages 0 and 1
        clear_log();
        bad_left = 0; busy_init = 3; poll_en = 1'b1;
        pg_first = PGW'(0); pg_count = PGW'(2);
        run_wait();
        chk("R11 done after run B", {done, err}, 2'b10);
        chk("R10 frame count with polls", nfr, 1 + 2*(2*PW+1+4));
        chk_page(1, 0, 4);
        chk_page(1 + 2*PW + 1 + 4, 1, 4);
        chk("R10 single reset when echo good", pulses, 1);

        // Run C: echo never correct
        clear_log();
        bad_left = 99; poll_en = 1'b0;
        run_wait();
        chk("R5 error flag", {done, err}, 2'b01);
        chk("R5 tries before error", nfr, MAXT);
        chk("R5 pulses before error", pulses, MAXT);
        chk("R4 last enable frame complete", bcnt, 0);
        repeat (1000) @(negedge clk);
        chk("R5 link quiet after error", {nfr, 1'b0, tgt_sck, tgt_rst, err}, {MAXT, 1'b0, 1'b0, 1'b0, 1'b1});

        // Run D: top page number, single page
        clear_log();
        bad_left = 0; busy_init = 0; poll_en = 1'b0;
        pg_first = {PGW{1'b1}}; pg_count = PGW'(1);
        run_wait();
        chk("R11 done top page", {done, err}, 2'b10);
        chk("R11 frame count top page", nfr, 1 + 2*PW + 1);
        chk_page(1, (1 << PGW) - 1, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule